// File: doc/BRIEF.md
# Strided Interleaved Vector Memory Unit

This block moves one vector between a vector register and a word-interleaved memory. A command supplies a base word address, a stride in words, an element count and a direction. The unit walks the elements in order and computes each element's address. It sends each access to one of sixteen banks of 64-bit words, and it holds back issue whenever the target bank is still recovering from its previous access.

A store reads each element from the vector register through a read port indexed by element number, and writes it into its bank when the element issues. A load reads the bank when the element issues. The data then passes through a fixed-latency return pipeline and comes out on a writeback port, tagged with its element index. A one-cycle done pulse marks the end of every command.

The memory is modelled inside the block as a synthesizable array of banks. Each bank has its own recovery timer, so the stride directly controls the throughput.

Top module: `vec_mem_unit`

## Requirements
- R1: Element i uses word address (base + i*stride) modulo 256. Bits [3:0] of that address select the bank, and bits [7:4] select the row within the bank.
- R2: A bank accepts its next access no sooner than 4 cycles after its previous one. While the next element's bank is recovering, issue stalls and element order is kept.
- R3: At most one element issues per cycle. The first element can issue in the cycle after the command is accepted. A unit stride issues one element per cycle, and a stride of 16 issues one element every 4 cycles.
- R4: A store writes element i into its bank when element i issues. The data is taken from `st_rd_data` in the cycle that `st_rd_idx` equals i. A later element that hits the same word overwrites an earlier one.
- R5: A load presents each element on `wb_data` with `wb_valid` high and `wb_idx` equal to i, exactly 12 cycles after element i issued. Writebacks come in element order.
- R6: `done` is high for one cycle. For a store, it is the cycle after the last element is written to its bank. For a load, it is the cycle after the last writeback.
- R7: A command with length 0 raises `done` in the next cycle. It makes no bank access and no writeback.
- R8: A length above 64 is treated as 64.
- R9: `cmd_ready` is high only while no command is in progress, including the cycle in which `done` is high. A `cmd_valid` seen while `cmd_ready` is low is ignored.
- R10: After reset, `cmd_ready` is 1, `wb_valid` is 0, `done` is 0, and every bank is free.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd_store | input | 1 | 1 = store, 0 = load |
| cmd_base | input | 8 | Base word address |
| cmd_stride | input | 8 | Stride in words, wraps modulo 256 |
| cmd_len | input | 7 | Element count |
| cmd_ready | output | 1 | Idle; a command is accepted when this and cmd_valid are high |
| st_rd_idx | output | 6 | Element index read from the vector register |
| st_rd_data | input | 64 | Vector register data for st_rd_idx, same cycle |
| wb_valid | output | 1 | Load writeback valid |
| wb_idx | output | 6 | Element index of the writeback |
| wb_data | output | 64 | Loaded word |
| done | output | 1 | Command completion pulse |

## Verification
During a long load, new elements keep issuing to banks while earlier elements are still returning on the writeback port. Issue, bank stall and writeback can therefore all happen in one cycle. Unit-stride and stride-16 loads of 64 and 16 elements are run so that the first writeback, 12 cycles in, lands while issue or a bank stall is still going on. A behavioural model schedules every issue cycle from the per-bank recovery rule. Each clock, the port values are compared against that model's expected writebacks, done pulses and ready level, so a returning element that is dropped, duplicated or mistimed is caught in the cycle it happens.

// File: rtl/vmu_pkg.sv
package vmu_pkg;
  typedef enum logic [1:0] {
    VMU_IDLE  = 2'd0,
    VMU_ISSUE = 2'd1,
    VMU_DRAIN = 2'd2
  } vmu_state_e;
endpackage

// File: rtl/vmu_addr_gen.sv
// Element walker: holds the current element index and word address.
module vmu_addr_gen #(
  parameter int ADDR_W = 8,
  parameter int IDX_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              step,
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W-1:0] stride,
  input  logic [IDX_W-1:0]  last_idx,
  output logic [ADDR_W-1:0] addr,
  output logic [IDX_W-1:0]  idx,
  output logic              last
);
  logic [ADDR_W-1:0] addr_q, addr_d, stride_q;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic              addr_en;

  always_comb begin
    addr_en = start | step;
    addr_d  = addr_q;
    idx_d   = idx_q;
    if (start) begin
      addr_d = base;
      idx_d  = '0;
    end else if (step) begin
      addr_d = addr_q + stride_q;
      idx_d  = idx_q + IDX_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q   <= '0;
      idx_q    <= '0;
      stride_q <= '0;
    end else begin
      if (addr_en) begin
        addr_q <= addr_d;
        idx_q  <= idx_d;
      end
      if (start) stride_q <= stride;
    end
  end

  assign addr = addr_q;
  assign idx  = idx_q;
  assign last = (idx_q == last_idx);
endmodule

// File: rtl/vmu_bank.sv
// One memory bank: storage rows plus a recovery timer.
module vmu_bank #(
  parameter int ROW_W    = 4,
  parameter int DATA_W   = 64,
  parameter int BUSY_CYC = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc,
  input  logic              wr,
  input  logic [ROW_W-1:0]  row,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              busy
);
  localparam int ROWS  = 1 << ROW_W;
  localparam int CNT_W = $clog2(BUSY_CYC + 1);

  logic [DATA_W-1:0] mem_q [ROWS];
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              wr_en;

  assign wr_en = acc & wr;

  always_ff @(posedge clk) begin
    if (wr_en) mem_q[row] <= wdata;
  end

  assign rdata = mem_q[row];

  always_comb begin
    cnt_d = cnt_q;
    if (acc)
      cnt_d = CNT_W'(BUSY_CYC - 1);
    else if (cnt_q != '0)
      cnt_d = cnt_q - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign busy = (cnt_q != '0);
endmodule

// File: rtl/vmu_load_pipe.sv
// Fixed-latency return path for load data, one stage per cycle.
module vmu_load_pipe #(
  parameter int DEPTH  = 12,
  parameter int IDX_W  = 6,
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [IDX_W-1:0]  in_idx,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  output logic [IDX_W-1:0]  out_idx,
  output logic [DATA_W-1:0] out_data
);
  logic              vld_q [DEPTH];
  logic [IDX_W-1:0]  idx_q [DEPTH];
  logic [DATA_W-1:0] dat_q [DEPTH];

  for (genvar s = 0; s < DEPTH; s++) begin : g_stage
    logic              src_v;
    logic [IDX_W-1:0]  src_i;
    logic [DATA_W-1:0] src_d;
    if (s == 0) begin : g_head
      assign src_v = in_valid;
      assign src_i = in_idx;
      assign src_d = in_data;
    end else begin : g_body
      assign src_v = vld_q[s-1];
      assign src_i = idx_q[s-1];
      assign src_d = dat_q[s-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) vld_q[s] <= 1'b0;
      else        vld_q[s] <= src_v;
    end

    always_ff @(posedge clk) begin
      if (src_v) begin
        idx_q[s] <= src_i;
        dat_q[s] <= src_d;
      end
    end
  end

  assign out_valid = vld_q[DEPTH-1];
  assign out_idx   = idx_q[DEPTH-1];
  assign out_data  = dat_q[DEPTH-1];
endmodule

// File: rtl/vec_mem_unit.sv
module vec_mem_unit
  import vmu_pkg::*;
#(
  parameter int NUM_BANKS   = 16,
  parameter int WORD_ADDR_W = 8,
  parameter int DATA_W      = 64,
  parameter int MAX_VL      = 64,
  parameter int BUSY_CYC    = 4,
  parameter int LOAD_LAT    = 12
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        cmd_valid,
  input  logic                        cmd_store,
  input  logic [WORD_ADDR_W-1:0]      cmd_base,
  input  logic [WORD_ADDR_W-1:0]      cmd_stride,
  input  logic [$clog2(MAX_VL):0]     cmd_len,
  output logic                        cmd_ready,
  output logic [$clog2(MAX_VL)-1:0]   st_rd_idx,
  input  logic [DATA_W-1:0]           st_rd_data,
  output logic                        wb_valid,
  output logic [$clog2(MAX_VL)-1:0]   wb_idx,
  output logic [DATA_W-1:0]           wb_data,
  output logic                        done
);
  localparam int BANK_W = $clog2(NUM_BANKS);
  localparam int ROW_W  = WORD_ADDR_W - BANK_W;
  localparam int IDX_W  = $clog2(MAX_VL);
  localparam int VL_W   = IDX_W + 1;

  vmu_state_e state_q, state_d;
  logic              done_q, done_d;
  logic              store_q;
  logic [IDX_W-1:0]  last_idx_q, last_idx_d;
  logic [VL_W-1:0]   len_clamped;
  logic              accept, issue, last_elem;
  logic [WORD_ADDR_W-1:0] cur_addr;
  logic [IDX_W-1:0]  cur_idx;
  logic [BANK_W-1:0] cur_bank;
  logic [ROW_W-1:0]  cur_row;
  logic [NUM_BANKS-1:0] bank_busy, bank_acc;
  logic [DATA_W-1:0] bank_rdata [NUM_BANKS];
  logic [DATA_W-1:0] rd_word;
  logic              ld_push;

  // command intake
  assign cmd_ready   = (state_q == VMU_IDLE);
  assign accept      = cmd_valid & cmd_ready;
  assign len_clamped = (cmd_len > VL_W'(MAX_VL)) ? VL_W'(MAX_VL) : cmd_len;
  assign last_idx_d  = IDX_W'(len_clamped - VL_W'(1));

  vmu_addr_gen #(.ADDR_W(WORD_ADDR_W), .IDX_W(IDX_W)) i_addr_gen (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (accept),
    .step     (issue),
    .base     (cmd_base),
    .stride   (cmd_stride),
    .last_idx (last_idx_q),
    .addr     (cur_addr),
    .idx      (cur_idx),
    .last     (last_elem)
  );

  assign cur_bank  = cur_addr[BANK_W-1:0];
  assign cur_row   = cur_addr[WORD_ADDR_W-1:BANK_W];
  assign issue     = (state_q == VMU_ISSUE) & ~bank_busy[cur_bank];
  assign st_rd_idx = cur_idx;

  // bank array
  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    assign bank_acc[b] = issue & (cur_bank == BANK_W'(b));
    vmu_bank #(.ROW_W(ROW_W), .DATA_W(DATA_W), .BUSY_CYC(BUSY_CYC)) i_bank (
      .clk   (clk),
      .rst_n (rst_n),
      .acc   (bank_acc[b]),
      .wr    (store_q),
      .row   (cur_row),
      .wdata (st_rd_data),
      .rdata (bank_rdata[b]),
      .busy  (bank_busy[b])
    );
  end

  assign rd_word = bank_rdata[cur_bank];
  assign ld_push = issue & ~store_q;

  vmu_load_pipe #(.DEPTH(LOAD_LAT), .IDX_W(IDX_W), .DATA_W(DATA_W)) i_load_pipe (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (ld_push),
    .in_idx    (cur_idx),
    .in_data   (rd_word),
    .out_valid (wb_valid),
    .out_idx   (wb_idx),
    .out_data  (wb_data)
  );

  // sequencing
  always_comb begin
    state_d = state_q;
    done_d  = 1'b0;
    case (state_q)
      VMU_IDLE: begin
        if (cmd_valid) begin
          if (len_clamped == '0) done_d = 1'b1;
          else                   state_d = VMU_ISSUE;
        end
      end
      VMU_ISSUE: begin
        if (issue && last_elem) begin
          if (store_q) begin
            state_d = VMU_IDLE;
            done_d  = 1'b1;
          end else begin
            state_d = VMU_DRAIN;
          end
        end
      end
      VMU_DRAIN: begin
        if (wb_valid && (wb_idx == last_idx_q)) begin
          state_d = VMU_IDLE;
          done_d  = 1'b1;
        end
      end
      default: state_d = VMU_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= VMU_IDLE;
      done_q     <= 1'b0;
      store_q    <= 1'b0;
      last_idx_q <= '0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
      if (accept) begin
        store_q    <= cmd_store;
        last_idx_q <= last_idx_d;
      end
    end
  end

  assign done = done_q;
endmodule

// File: rtl/vmu_chk.sv
module vmu_chk #(
  parameter int NUM_BANKS = 16,
  parameter int BUSY_CYC  = 4,
  parameter int IDX_W     = 6
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [NUM_BANKS-1:0] bank_acc,
  input logic                 cmd_valid,
  input logic                 cmd_ready,
  input logic                 wb_valid,
  input logic [IDX_W-1:0]     wb_idx,
  input logic                 done
);
  localparam int CW = $clog2(BUSY_CYC + 1);

  logic [CW-1:0]    since_q [NUM_BANKS];
  logic             seen_q;
  logic [IDX_W-1:0] prev_q;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_gap
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        since_q[b] <= CW'(BUSY_CYC);
      else if (bank_acc[b])              since_q[b] <= CW'(1);
      else if (since_q[b] < CW'(BUSY_CYC)) since_q[b] <= since_q[b] + CW'(1);
    end

    // R2
    bank_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bank_acc[b] |-> (since_q[b] >= CW'(BUSY_CYC)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q <= 1'b0;
      prev_q <= '0;
    end else if (cmd_valid && cmd_ready) begin
      seen_q <= 1'b0;
    end else if (wb_valid) begin
      seen_q <= 1'b1;
      prev_q <= wb_idx;
    end
  end

  // R5
  wb_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_valid && !seen_q) |-> (wb_idx == '0));

  // R5
  wb_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_valid && seen_q) |-> (wb_idx == prev_q + IDX_W'(1)));

  // R6
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> cmd_ready);

  // R9
  wb_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> !cmd_ready);
endmodule

bind vec_mem_unit vmu_chk #(
  .NUM_BANKS (NUM_BANKS),
  .BUSY_CYC  (BUSY_CYC),
  .IDX_W     (IDX_W)
) i_vmu_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bank_acc  (bank_acc),
  .cmd_valid (cmd_valid),
  .cmd_ready (cmd_ready),
  .wb_valid  (wb_valid),
  .wb_idx    (wb_idx),
  .done      (done)
);

// File: tb/test_vec_mem_unit.sv
module test_vec_mem_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cmd_valid, cmd_store;
  logic [7:0]  cmd_base, cmd_stride;
  logic [6:0]  cmd_len;
  logic        cmd_ready;
  logic [5:0]  st_rd_idx;
  logic [63:0] st_rd_data;
  logic        wb_valid;
  logic [5:0]  wb_idx;
  logic [63:0] wb_data;
  logic        done;

  always #5 clk = ~clk;

  vec_mem_unit i_vec_mem_unit (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_store(cmd_store),
    .cmd_base(cmd_base), .cmd_stride(cmd_stride), .cmd_len(cmd_len),
    .cmd_ready(cmd_ready), .st_rd_idx(st_rd_idx), .st_rd_data(st_rd_data),
    .wb_valid(wb_valid), .wb_idx(wb_idx), .wb_data(wb_data), .done(done)
  );

  logic [63:0] vreg [64];
  assign st_rd_data = vreg[st_rd_idx];

  logic [63:0] mem_m [256];
  int          last_use [16];
  int          exp_wb_idx [int];
  logic [63:0] exp_wb_dat [int];
  bit          exp_done [int];
  int          cyc = 0;
  int          busy_from = 0;
  int          ready_from = 0;
  bit          chk_en = 1'b0;
  int          n_tests = 0;
  int          n_fail = 0;
  string       tag = "R10";

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(string t, string what, logic [63:0] act, logic [63:0] expv);
    n_tests++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s %s at cycle %0d: got %h expected %h", t, what, cyc, act, expv);
    end
  endtask

  // per-cycle comparison against the behavioural schedule
  always @(negedge clk) begin
    bit ev;
    if (chk_en) begin
      ev = exp_wb_idx.exists(cyc) ? 1'b1 : 1'b0;
      check(tag, "wb_valid", 64'(wb_valid), 64'(ev));
      if (ev && wb_valid) begin
        check(tag, "wb_idx", 64'(wb_idx), 64'(exp_wb_idx[cyc]));
        check(tag, "wb_data", wb_data, exp_wb_dat[cyc]);
      end
      check("R6", "done", 64'(done), 64'(exp_done.exists(cyc) ? 1 : 0));
      check("R9", "cmd_ready", 64'(cmd_ready),
            64'((cyc > busy_from && cyc < ready_from) ? 0 : 1));
    end
  end

  task automatic fill_vreg(int seed);
    for (int i = 0; i < 64; i++) vreg[i] = {32'(seed), 32'(i * 7 + 1)};
  endtask

  task automatic run_cmd(bit st, int base, int stride, int len, string t);
    int a, c, le, ad, bk;
    while (cyc < ready_from) @(negedge clk);
    @(negedge clk);
    tag = t;
    cmd_valid = 1'b1; cmd_store = st;
    cmd_base = 8'(base); cmd_stride = 8'(stride); cmd_len = 7'(len);
    a = cyc;
    busy_from = a;
    le = (len > 64) ? 64 : len;
    if (le == 0) begin
      exp_done[a+1] = 1'b1;
      ready_from = a + 1;
    end else begin
      c = a;
      for (int i = 0; i < le; i++) begin
        ad = (base + i * stride) % 256;
        bk = ad % 16;
        c = (c + 1 > last_use[bk] + 4) ? c + 1 : last_use[bk] + 4;
        last_use[bk] = c;
        if (st) mem_m[ad] = vreg[i];
        else begin
          exp_wb_idx[c+12] = i;
          exp_wb_dat[c+12] = mem_m[ad];
        end
      end
      if (st) begin exp_done[c+1] = 1'b1;  ready_from = c + 1;  end
      else    begin exp_done[c+13] = 1'b1; ready_from = c + 13; end
    end
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  initial begin
    #2000000;
    n_tests++; n_fail++;
    $display("FAIL watchdog expired at cycle %0d", cyc);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    for (int b = 0; b < 16; b++) last_use[b] = -100;
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_store = 1'b0;
    cmd_base = '0; cmd_stride = '0; cmd_len = '0;
    fill_vreg(0);
    repeat (3) @(negedge clk);
    check("R10", "reset cmd_ready", 64'(cmd_ready), 64'd1);
    check("R10", "reset wb_valid", 64'(wb_valid), 64'd0);
    check("R10", "reset done", 64'(done), 64'd0);
    rst_n = 1'b1;
    busy_from = cyc; ready_from = cyc;
    chk_en = 1'b1;

    // R4 fill the whole memory with unit-stride stores
    for (int k = 0; k < 4; k++) begin
      while (cyc < ready_from) @(negedge clk);
      fill_vreg(100 + k);
      run_cmd(1'b1, k * 64, 1, 64, "R4 R3");
    end
    // R3 R5 unit-stride load, issue overlaps writeback
    run_cmd(1'b0, 5, 1, 64, "R3 R5");
    // R2 stride 16 keeps hitting one bank
    run_cmd(1'b0, 3, 16, 16, "R2 R3");
    // R1 address wrap with odd stride
    run_cmd(1'b0, 250, 3, 20, "R1");
    // R2 stride 4 revisits bank every 4 elements
    run_cmd(1'b0, 1, 4, 10, "R2");
    // R4 stride 0 store: last element wins, then read back
    while (cyc < ready_from) @(negedge clk);
    fill_vreg(7);
    run_cmd(1'b1, 77, 0, 5, "R4 R2");
    run_cmd(1'b0, 76, 1, 3, "R4");
    // R7 zero length
    run_cmd(1'b0, 0, 1, 0, "R7");
    run_cmd(1'b1, 0, 1, 0, "R7");
    // R8 oversize length on a store, then read back past element 63
    while (cyc < ready_from) @(negedge clk);
    fill_vreg(55);
    run_cmd(1'b1, 128, 2, 100, "R8");
    run_cmd(1'b0, 128, 1, 127, "R8 R1");
    // R9 command while busy is ignored
    run_cmd(1'b0, 9, 16, 12, "R9");
    repeat (5) @(negedge clk);
    cmd_valid = 1'b1; cmd_store = 1'b1; cmd_base = 8'd9; cmd_stride = 8'd1; cmd_len = 7'd5;
    @(negedge clk);
    cmd_valid = 1'b0;
    run_cmd(1'b0, 9, 1, 8, "R9 R5");

    while (cyc < ready_from + 4) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule